// File: doc/BRIEF.md
# Staggered Threshold Waveform Generator

The block runs a free counter through a 256-clock period and produces seven level waveforms from it. Each waveform changes level at one fixed count within the period. Four waveforms start the period low and go high after a short leading gap. The gaps are staggered by one clock each. The other three start high and drop near the end of the period, again one clock apart. The current count is also brought out, so a neighbour can align to the period.

Every output comes straight from a flip-flop, so no decode hazard reaches a port. This matters most at counts such as 127 to 128, where many counter bits flip at once. Each output is a set/clear register, so the block decodes only its set and clear points. One decode of the final count serves all of them. Only the first edge of each staggered group is decoded; every later edge in the group comes from the register of its neighbour. The count-enable input freezes the whole block in place. The synchronous reset puts it into its count-0 state.

Top module: `phase_wave_gen`

## Requirements
- R1: While `en` is 1 and `rst` is 0, `cnt_o` increments by one on each clock and wraps from 255 to 0.
- R2: A clock edge with `rst` at 1 makes `cnt_o` 0 and `wave_o` 7'b1110000. That is, bits 3..0 are low and bits 6..4 are high, which matches the count-0 state. `rst` wins over `en`.
- R3: For k in 0..3, `wave_o[k]` is 0 while `cnt_o` is at most 4-k and 1 for the rest of the period. So bit 0 is low for counts 0–4, bit 1 for 0–3, bit 2 for 0–2 and bit 3 for 0–1.
- R4: For j in 0..2, `wave_o[4+j]` is 1 while `cnt_o` is at most 251+j and 0 for the rest of the period. So bit 4 is high for counts 0–251, bit 5 for 0–252 and bit 6 for 0–253.
- R5: Bit 3 rises one clock after the count-1 decode. Each lower bit k (k = 2, 1, 0) rises exactly one clock after bit k+1 was high.
- R6: Bits 3..0 all clear together on the step from count 255 to count 0.
- R7: Bits 6..4 all set together on the step from count 255 to count 0. Bit 4 is the only one cleared by a count decode, at count 251. Bits 5 and 6 each fall one clock after their lower neighbour.
- R8: While `en` is 0, `cnt_o` and `wave_o` keep their values. When `en` returns to 1, the sequence continues from the held count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Count enable; 0 freezes the counter and all waveforms |
| cnt_o | output | 8 | Present count within the 256-clock period |
| wave_o | output | 7 | Waveforms; bits 3..0 rise late, bits 6..4 fall early |

## Verification
Each waveform register holds its own level, so a wrong internal state stays visible and does not fade. A missed set, clear or chain link shows on a port within one clock of the count where that edge belongs. It then persists until the count-255 decode forces the group back to its known level, at most 256 clocks later. A fault in the counter skews all seven edges at once. A broken link in a chain shifts or removes every edge below it in that group. The bench therefore checks the waveforms at every count of a full period, as well as at the edge counts themselves and across a frozen interval.

// File: rtl/phase_wave_gen.sv
module phase_wave_gen #(
  parameter int CW     = 8,
  parameter int RISE_N = 4,
  parameter int FALL_N = 3,
  parameter int SET_AT = 1,
  parameter int CLR_AT = 251
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       en,
  output logic [CW-1:0]              cnt_o,
  output logic [RISE_N+FALL_N-1:0]   wave_o
);
  localparam logic [CW-1:0] LAST   = {CW{1'b1}};
  localparam logic [CW-1:0] SET_PT = CW'(SET_AT);
  localparam logic [CW-1:0] CLR_PT = CW'(CLR_AT);

  logic [CW-1:0]     cnt;
  logic [RISE_N-1:0] rise_q, rise_set;
  logic [FALL_N-1:0] fall_q, fall_clr;

  wire at_last = (cnt == LAST);
  wire at_set  = (cnt == SET_PT);
  wire at_clr  = (cnt == CLR_PT);

  generate
    if (RISE_N > 1) begin : g_rise_chain
      assign rise_set = {at_set, rise_q[RISE_N-1:1]};
    end else begin : g_rise_single
      assign rise_set = at_set;
    end
    if (FALL_N > 1) begin : g_fall_chain
      assign fall_clr = {~fall_q[FALL_N-2:0], at_clr};
    end else begin : g_fall_single
      assign fall_clr = at_clr;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      rise_q <= '0;
      fall_q <= '1;
    end else if (en) begin
      cnt    <= cnt + 1'b1;
      rise_q <= at_last ? '0 : (rise_q | rise_set);
      fall_q <= at_last ? '1 : (fall_q & ~fall_clr);
    end
  end

  assign cnt_o  = cnt;
  assign wave_o = {fall_q, rise_q};

  a_r1_count_step: assert property (@(posedge clk) disable iff (rst)
    en |=> cnt == CW'($past(cnt) + 1'b1));

  a_r2_reset_state: assert property (@(posedge clk)
    rst |=> (cnt == '0) && (rise_q == '0) && (fall_q == '1));

  a_r3_first_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(rise_q[RISE_N-1]) |-> cnt == CW'(SET_AT + 1));

  a_r3_last_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(rise_q[0]) |-> cnt == CW'(SET_AT + RISE_N));

  a_r4_first_fall: assert property (@(posedge clk) disable iff (rst)
    $fell(fall_q[0]) |-> cnt == CW'(CLR_AT + 1));

  generate
    for (genvar i = 0; i < RISE_N - 1; i++) begin : g_rise_chk
      a_r5_chain_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(rise_q[i]) |-> $past(rise_q[i+1]));
    end
    for (genvar j = 1; j < FALL_N; j++) begin : g_fall_chk
      a_r7_chain_fall: assert property (@(posedge clk) disable iff (rst)
        $fell(fall_q[j]) |-> !$past(fall_q[j-1]));
    end
  endgenerate

  a_r6_rise_clear: assert property (@(posedge clk) disable iff (rst)
    (cnt == '0) |-> rise_q == '0);

  a_r7_fall_set: assert property (@(posedge clk) disable iff (rst)
    (cnt == '0) |-> fall_q == '1);

  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(cnt) && $stable(wave_o));
endmodule

// File: tb/tb_phase_wave_gen.sv
`timescale 1ns/1ps
module tb_phase_wave_gen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en  = 1'b0;
  logic [7:0] cnt_o;
  logic [6:0] wave_o;
  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  phase_wave_gen dut (.clk(clk), .rst(rst), .en(en), .cnt_o(cnt_o), .wave_o(wave_o));

  localparam int NV = 15;
  localparam logic [14:0] VEC [NV] = '{
    {8'd0,   7'b1110000}, {8'd1,   7'b1110000}, {8'd2,   7'b1111000},
    {8'd3,   7'b1111100}, {8'd4,   7'b1111110}, {8'd5,   7'b1111111},
    {8'd127, 7'b1111111}, {8'd128, 7'b1111111}, {8'd250, 7'b1111111},
    {8'd251, 7'b1111111}, {8'd252, 7'b1101111}, {8'd253, 7'b1001111},
    {8'd254, 7'b0001111}, {8'd255, 7'b0001111}, {8'd0,   7'b1110000}
  };

  function automatic logic [6:0] model(input int c);
    logic [6:0] w;
    for (int k = 0; k < 4; k++) w[k] = (c > 4 - k);
    for (int j = 0; j < 3; j++) w[4+j] = (c <= 251 + j);
    return w;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_count(input int c);
    for (int n = 0; n < 600; n++) begin
      @(negedge clk);
      if (cnt_o == 8'(c)) return;
    end
    chk("R1 count never reached", cnt_o, c);
  endtask

  initial begin
    #(5.0 * 190000);
    chk("watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [6:0] prev;
    repeat (3) @(negedge clk);
    chk("R2 reset count", cnt_o, 0);
    chk("R2 reset waves", wave_o, 7'b1110000);

    en = 1'b1; rst = 1'b0;
    @(negedge clk);
    chk("R1 first step", cnt_o, 1);

    for (int v = 1; v < NV; v++) begin
      wait_count(VEC[v][14:7]);
      chk("R3/R4 table waves", wave_o, VEC[v][6:0]);
    end

    wait_count(0);
    prev = wave_o;
    for (int c = 0; c < 256; c++) begin
      chk("R1 scan count", cnt_o, c);
      chk("R3/R4 scan waves", wave_o, model(c));
      if (c >= 2 && c <= 5)
        chk("R5 one new rise", $countones(wave_o[3:0] & ~prev[3:0]), 1);
      if (c == 0) begin
        chk("R6 rises cleared", wave_o[3:0], 0);
        chk("R7 falls set", wave_o[6:4], 7);
      end
      prev = wave_o;
      @(negedge clk);
    end
    chk("R1 wrap to zero", cnt_o, 0);

    wait_count(252);
    en = 1'b0;
    repeat (6) @(negedge clk);
    chk("R8 hold count", cnt_o, 252);
    chk("R8 hold waves", wave_o, 7'b1101111);
    en = 1'b1;
    @(negedge clk);
    chk("R8 resume count", cnt_o, 253);
    chk("R7 chained fall", wave_o, 7'b1001111);

    wait_count(255);
    en = 1'b0;
    repeat (4) @(negedge clk);
    chk("R8 hold at last", wave_o, 7'b0001111);
    en = 1'b1;
    @(negedge clk);
    chk("R6 clear after hold", wave_o[3:0], 0);
    chk("R7 set after hold", wave_o[6:4], 7);

    wait_count(100);
    rst = 1'b1;
    @(negedge clk);
    chk("R2 mid-run reset count", cnt_o, 0);
    chk("R2 mid-run reset waves", wave_o, 7'b1110000);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 restart", cnt_o, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule